// File: doc/BRIEF.md
# Single-Port SRAM March Test Engine

This block is a built-in self-test controller for one single-port SRAM. Software or a test sequencer pulses `start` with an algorithm code. The engine then drives the memory's address, write data and strobes through every element of the chosen march test. It checks each word read back against the expected background, and reports the outcome when the run is complete. Word width and depth are parameters, so one design serves memories of any shape.

The seven algorithms are held as a small microcode table. Each entry gives an element's address direction, whether it has one or two operations per address, the read/write kind and value of each operation, and whether the data is a solid or a checkerboard background. A per-instance enable mask stops algorithms that a given memory must not run. Reads may return after a variable delay. The engine waits for the valid strobe before it moves on. It also records the first mismatch it sees and still runs the test to the end.

Top module: `sram_march_bist`

## Requirements
- R1: After synchronous reset the engine is idle: `busy`, `done`, `fail`, `mem_we` and `mem_re` are low.
- R2: Algorithm codes run these elements, and take the stated numbers of memory operations for depth n. 0 zero-one {w0; r0; w1; r1} takes 4n. 1 checkerboard {w0c; r0c; w1c; r1c} takes 4n. 2 three-element {w0; r0,w1; r1} takes 4n. 3 {w0; up r0,w1; down r1,w0} takes 5n. 4 is code 3 plus a final r0, for 6n. 5 {w0; up r0,w1; up r1,w0; r0; down r0,w1; down r1,w0; r0} takes 11n. 6 is code 5 without its fourth element, for 10n.
- R3: Elements without a stated direction, and ascending elements, visit addresses 0 to n-1. Descending elements visit n-1 down to 0. A two-operation element performs both operations at one address before it steps.
- R4: A solid background writes all zeros or all ones. In a checkerboard background, bit i of the word at address a equals (i mod 2) xor a[0] xor p, where p is the pass value. With 4-bit words this gives hex A at even and 5 at odd addresses for p=0, and the inverse for p=1.
- R5: Only one memory operation is issued per cycle, and `mem_we` and `mem_re` are never high together. After a read, no further operation is issued until `rd_valid` returns the data.
- R6: On a fault-free memory every algorithm finishes with `fail` low.
- R7: The first read that differs from its expected word sets `fail` and latches its address, expected word and actual word. Later mismatches do not change them. The run continues to completion. A new accepted start clears them.
- R8: `done` is high for exactly one cycle after the last operation of the last element, with `busy` low. `fail` and the latched fields hold until the next accepted start.
- R9: A start whose code is 7, or whose bit in `alg_en` is 0, issues no memory operation, raises no `done` and leaves the status unchanged.
- R10: A start pulse while a test is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled when idle |
| alg_sel | input | 3 | Algorithm code (0 to 6) |
| alg_en | input | 7 | Per-algorithm enable mask, bit k enables code k |
| mem_addr | output | $clog2(DEPTH) | Memory address |
| mem_wdata | output | W | Memory write data |
| mem_we | output | 1 | Write strobe, one cycle per write |
| mem_re | output | 1 | Read strobe, one cycle per read |
| rd_data | input | W | Read data from the memory |
| rd_valid | input | 1 | Read data valid strobe |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | A mismatch was seen in the last test |
| fail_addr | output | $clog2(DEPTH) | Address of the first mismatch |
| fail_exp | output | W | Expected word at the first mismatch |
| fail_act | output | W | Word actually read at the first mismatch |

## Verification
The bench builds the engine with 4-bit words and a depth of 8. At that size every algorithm can be run in full and its whole operation trace compared with arithmetic expectations: operation counts, per-element address order and checkerboard words at both address parities. The memory model answers reads after a latency that cycles through one to three cycles. Stuck-at bits placed at chosen addresses make the first-fail address show which direction each element runs.

// File: rtl/march_pkg.sv
package march_pkg;

  localparam int NUM_ALGS = 7;
  localparam int ALG_W    = 3;
  localparam int ELEM_W   = 3;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_FIN} bist_state_e;

  // One march element: direction, one or two ops, op kinds/values, background
  typedef struct packed {
    logic last;   // final element of the algorithm
    logic down;   // descending address order
    logic two;    // two operations per address
    logic rd0;    // first op is a read
    logic v0;     // first op value
    logic rd1;    // second op is a read
    logic v1;     // second op value
    logic chk;    // checkerboard background
  } elem_t;

  function automatic elem_t mk(logic last, logic down, logic two, logic rd0,
                               logic v0, logic rd1, logic v1, logic chk);
    elem_t e;
    e.last = last; e.down = down; e.two = two; e.rd0 = rd0;
    e.v0 = v0; e.rd1 = rd1; e.v1 = v1; e.chk = chk;
    return e;
  endfunction

  function automatic elem_t ucode(logic [ALG_W-1:0] alg, logic [ELEM_W-1:0] idx);
    elem_t e;
    e = mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    case ({alg, idx})
      // code 0: solid zero-one
      6'o00: e = mk(0, 0, 0, 0, 0, 0, 0, 0);
      6'o01: e = mk(0, 0, 0, 1, 0, 0, 0, 0);
      6'o02: e = mk(0, 0, 0, 0, 1, 0, 0, 0);
      6'o03: e = mk(1, 0, 0, 1, 1, 0, 0, 0);
      // code 1: checkerboard
      6'o10: e = mk(0, 0, 0, 0, 0, 0, 0, 1);
      6'o11: e = mk(0, 0, 0, 1, 0, 0, 0, 1);
      6'o12: e = mk(0, 0, 0, 0, 1, 0, 0, 1);
      6'o13: e = mk(1, 0, 0, 1, 1, 0, 0, 1);
      // code 2: three elements
      6'o20: e = mk(0, 0, 0, 0, 0, 0, 0, 0);
      6'o21: e = mk(0, 0, 1, 1, 0, 0, 1, 0);
      6'o22: e = mk(1, 0, 0, 1, 1, 0, 0, 0);
      // code 3
      6'o30: e = mk(0, 0, 0, 0, 0, 0, 0, 0);
      6'o31: e = mk(0, 0, 1, 1, 0, 0, 1, 0);
      6'o32: e = mk(1, 1, 1, 1, 1, 0, 0, 0);
      // code 4
      6'o40: e = mk(0, 0, 0, 0, 0, 0, 0, 0);
      6'o41: e = mk(0, 0, 1, 1, 0, 0, 1, 0);
      6'o42: e = mk(0, 1, 1, 1, 1, 0, 0, 0);
      6'o43: e = mk(1, 0, 0, 1, 0, 0, 0, 0);
      // code 5
      6'o50: e = mk(0, 0, 0, 0, 0, 0, 0, 0);
      6'o51: e = mk(0, 0, 1, 1, 0, 0, 1, 0);
      6'o52: e = mk(0, 0, 1, 1, 1, 0, 0, 0);
      6'o53: e = mk(0, 0, 0, 1, 0, 0, 0, 0);
      6'o54: e = mk(0, 1, 1, 1, 0, 0, 1, 0);
      6'o55: e = mk(0, 1, 1, 1, 1, 0, 0, 0);
      6'o56: e = mk(1, 0, 0, 1, 0, 0, 0, 0);
      // code 6
      6'o60: e = mk(0, 0, 0, 0, 0, 0, 0, 0);
      6'o61: e = mk(0, 0, 1, 1, 0, 0, 1, 0);
      6'o62: e = mk(0, 0, 1, 1, 1, 0, 0, 0);
      6'o63: e = mk(0, 1, 1, 1, 0, 0, 1, 0);
      6'o64: e = mk(0, 1, 1, 1, 1, 0, 0, 0);
      6'o65: e = mk(1, 0, 0, 1, 0, 0, 0, 0);
      default: ;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/march_addr.sv
module march_addr #(
  parameter int DEPTH = 256,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          load_down,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          at_end
);

  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic down_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      down_q <= 1'b0;
    end else if (load) begin
      addr   <= load_down ? TOP : '0;
      down_q <= load_down;
    end else if (step) begin
      addr   <= down_q ? addr - 1'b1 : addr + 1'b1;
    end
  end

  assign at_end = down_q ? (addr == '0) : (addr == TOP);

  a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
    addr <= TOP);

  a_r3_step_up: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !down_q) |=> (addr == $past(addr) + 1'b1));

  a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
    (step && !load && down_q) |=> (addr == $past(addr) - 1'b1));

endmodule

// File: rtl/march_cmp.sv
module march_cmp #(
  parameter int W  = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          chk_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  exp_d,
  input  logic [W-1:0]  act_d,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [W-1:0]  fail_exp,
  output logic [W-1:0]  fail_act
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_act  <= '0;
    end else if (chk_en && !fail && (act_d != exp_d)) begin
      fail      <= 1'b1;
      fail_addr <= addr;
      fail_exp  <= exp_d;
      fail_act  <= act_d;
    end
  end

  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (fail && !clr) |=> (fail && $stable(fail_addr) && $stable(fail_act)));

  a_r7_rise_on_read: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> $past(chk_en));

endmodule

// File: rtl/sram_march_bist.sv
module sram_march_bist
  import march_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 256,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [ALG_W-1:0]    alg_sel,
  input  logic [NUM_ALGS-1:0] alg_en,
  output logic [AW-1:0]       mem_addr,
  output logic [W-1:0]        mem_wdata,
  output logic                mem_we,
  output logic                mem_re,
  input  logic [W-1:0]        rd_data,
  input  logic                rd_valid,
  output logic                busy,
  output logic                done,
  output logic                fail,
  output logic [AW-1:0]       fail_addr,
  output logic [W-1:0]        fail_exp,
  output logic [W-1:0]        fail_act
);

  bist_state_e       state;
  logic [ALG_W-1:0]  alg_q;
  logic [ELEM_W-1:0] elem_q;
  logic              op_q;
  logic [W-1:0]      exp_q;

  elem_t             cur;
  logic              nxt_down;
  logic              op_rd, op_pol, last_op, adv, start_ok, fin_now;
  logic              ld, ld_down, step, at_end;
  logic [AW-1:0]     addr;
  logic [W-1:0]      bg;
  logic [7:0]        en_ext;

  assign en_ext   = 8'({1'b0, alg_en});
  assign start_ok = (state == S_IDLE) && start && en_ext[alg_sel];

  assign cur      = ucode(alg_q, elem_q);
  assign nxt_down = ucode(alg_q, elem_q + 1'b1).down;
  assign op_rd    = op_q ? cur.rd1 : cur.rd0;
  assign op_pol   = op_q ? cur.v1  : cur.v0;
  assign last_op  = !cur.two || op_q;

  assign adv      = ((state == S_ISSUE) && !op_rd) || ((state == S_WAIT) && rd_valid);
  assign fin_now  = adv && last_op && at_end && cur.last;
  assign ld       = start_ok || (adv && last_op && at_end && !cur.last);
  assign ld_down  = (state == S_IDLE) ? 1'b0 : nxt_down;
  assign step     = adv && last_op && !at_end;

  // data background: solid value or address-parity checkerboard
  always_comb begin
    for (int i = 0; i < W; i++) begin
      bg[i] = cur.chk ? (op_pol ^ addr[0] ^ i[0]) : op_pol;
    end
  end

  march_addr #(.DEPTH(DEPTH)) u_addr (
    .clk(clk), .rst(rst), .load(ld), .load_down(ld_down),
    .step(step), .addr(addr), .at_end(at_end)
  );

  march_cmp #(.W(W), .AW(AW)) u_cmp (
    .clk(clk), .rst(rst), .clr(start_ok),
    .chk_en((state == S_WAIT) && rd_valid),
    .addr(mem_addr), .exp_d(exp_q), .act_d(rd_data),
    .fail(fail), .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_act(fail_act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      alg_q     <= '0;
      elem_q    <= '0;
      op_q      <= 1'b0;
      exp_q     <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      done   <= 1'b0;
      case (state)
        S_IDLE: if (start_ok) begin
          alg_q  <= alg_sel;
          elem_q <= '0;
          op_q   <= 1'b0;
          busy   <= 1'b1;
          state  <= S_ISSUE;
        end
        S_ISSUE: begin
          mem_addr  <= addr;
          mem_wdata <= op_rd ? '0 : bg;
          mem_we    <= !op_rd;
          mem_re    <= op_rd;
          exp_q     <= bg;
          if (op_rd) state <= S_WAIT;
        end
        S_FIN: begin
          busy  <= 1'b0;
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: ;
      endcase
      if (adv) begin
        op_q  <= !last_op;
        state <= fin_now ? S_FIN : S_ISSUE;
        if (last_op && at_end && !cur.last) elem_q <= elem_q + 1'b1;
      end
    end
  end

  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  a_r5_stall: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && !rd_valid) |=> (!mem_we && !mem_re));

  a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_idle_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r9_access_busy: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |-> busy);

  a_r9_reject: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && start && !start_ok) |=> (state == S_IDLE && !busy));

endmodule

// File: tb/sim_sram_march_bist.sv
`timescale 1ns/1ps
module sim_sram_march_bist;
  localparam int W = 4;
  localparam int DEPTH = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          start = 1'b0;
  logic [2:0]    alg_sel = '0;
  logic [6:0]    alg_en = 7'h7F;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [W-1:0]  mem_wdata, fail_exp, fail_act;
  logic [W-1:0]  rd_data;
  logic          mem_we, mem_re, rd_valid, busy, done, fail;

  sram_march_bist #(.W(W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .start(start), .alg_sel(alg_sel), .alg_en(alg_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done),
    .fail(fail), .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_act(fail_act)
  );

  // memory model with stuck-at faults, variable read latency and op trace
  logic [W-1:0]  mem [DEPTH];
  logic [W-1:0]  sa0 [DEPTH];
  logic [W-1:0]  sa1 [DEPTH];
  logic [AW-1:0] tr_a [256];
  logic [W-1:0]  tr_d [256];
  logic          tr_w [256];
  int            op_n, done_n, viol;
  logic          pend;
  logic [1:0]    pcnt, lat;
  logic [AW-1:0] paddr;

  always @(posedge clk) begin
    if (rst) begin
      op_n <= 0; done_n <= 0; viol <= 0; pend <= 1'b0;
      rd_valid <= 1'b0; rd_data <= '0; lat <= 2'd1; pcnt <= 2'd0; paddr <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_we || mem_re) begin
        tr_a[op_n[7:0]] <= mem_addr;
        tr_d[op_n[7:0]] <= mem_wdata;
        tr_w[op_n[7:0]] <= mem_we;
        op_n <= op_n + 1;
        if (pend) viol <= viol + 1;
      end
      if (mem_re) begin
        pend  <= 1'b1;
        pcnt  <= lat;
        paddr <= mem_addr;
        lat   <= (lat == 2'd3) ? 2'd1 : lat + 2'd1;
      end else if (pend) begin
        if (pcnt == 2'd1) begin
          rd_valid <= 1'b1;
          rd_data  <= (mem[paddr] & ~sa0[paddr]) | sa1[paddr];
          pend     <= 1'b0;
        end else begin
          pcnt <= pcnt - 2'd1;
        end
      end
      if (done) done_n <= done_n + 1;
    end
  end

  int checks = 0;
  int errors = 0;
  int base, dn0;

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start_run(input logic [2:0] alg, input logic [6:0] mask);
    @(negedge clk);
    alg_en = mask; alg_sel = alg; start = 1'b1;
    base = op_n; dn0 = done_n;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic clear_faults();
    for (int a = 0; a < DEPTH; a++) begin
      sa0[a] = '0; sa1[a] = '0;
    end
  endtask

  function automatic logic [7:0] ix(input int j);
    return 8'(base + j);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int mult [7] = '{4, 4, 4, 5, 6, 11, 10};
    int elen [7] = '{1, 2, 2, 1, 2, 2, 1};
    bit edn  [7] = '{0, 0, 0, 0, 1, 1, 0};
    int bad, idx;
    logic [W-1:0] ew;

    clear_faults();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1 reset outputs", {busy, done, fail, mem_we, mem_re}, 5'b0);

    // every algorithm on a clean memory
    for (int a = 0; a < 7; a++) begin
      start_run(3'(a), 7'h7F);
      wait_done();
      check_eq($sformatf("R2 op count alg %0d", a), op_n - base, mult[a] * DEPTH);
      check_eq($sformatf("R6 clean pass alg %0d", a), fail, 1'b0);
      check_eq($sformatf("R8 busy low at done alg %0d", a), busy, 1'b0);
      if (a == 0) begin
        bad = 0;
        for (int j = 0; j < DEPTH; j++) begin
          if (tr_d[ix(2*DEPTH + j)] !== 4'hF || tr_a[ix(2*DEPTH + j)] !== 3'(j) ||
              tr_w[ix(2*DEPTH + j)] !== 1'b1) bad++;
        end
        check_eq("R4 solid ones pass", bad, 0);
      end
      if (a == 1) begin
        bad = 0;
        for (int j = 0; j < DEPTH; j++) begin
          ew = (j % 2 == 0) ? 4'hA : 4'h5;
          if (tr_d[ix(j)] !== ew || tr_w[ix(j)] !== 1'b1) bad++;
          if (tr_d[ix(2*DEPTH + j)] !== ~ew || tr_w[ix(2*DEPTH + j)] !== 1'b1) bad++;
          if (tr_w[ix(DEPTH + j)] !== 1'b0) bad++;
        end
        check_eq("R4 checkerboard words", bad, 0);
      end
      if (a == 3) begin
        bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
          if (tr_a[ix(3*DEPTH + 2*i)] !== 3'(DEPTH-1-i) ||
              tr_a[ix(3*DEPTH + 2*i + 1)] !== 3'(DEPTH-1-i)) bad++;
          if (tr_w[ix(3*DEPTH + 2*i)] !== 1'b0 || tr_w[ix(3*DEPTH + 2*i + 1)] !== 1'b1) bad++;
        end
        check_eq("R3 descending read-write pairs", bad, 0);
      end
      if (a == 5) begin
        bad = 0; idx = 0;
        for (int e = 0; e < 7; e++) begin
          for (int i = 0; i < DEPTH; i++) begin
            for (int o = 0; o < elen[e]; o++) begin
              if (tr_a[ix(idx)] !== (edn[e] ? 3'(DEPTH-1-i) : 3'(i))) bad++;
              idx++;
            end
          end
        end
        check_eq("R3 eleven-element address order", bad, 0);
      end
      @(negedge clk);
      check_eq($sformatf("R8 done single cycle alg %0d", a), done, 1'b0);
    end

    // stuck-at-0 on bit 0 at addresses 2 and 5
    clear_faults();
    sa0[2] = 4'b0001; sa0[5] = 4'b0001;
    start_run(3'd3, 7'h7F);
    wait_done();
    check_eq("R7 fail flag", fail, 1'b1);
    check_eq("R7 first fail address on descending pass", fail_addr, 3'd5);
    check_eq("R7 expected word", fail_exp, 4'hF);
    check_eq("R7 actual word", fail_act, 4'hE);
    check_eq("R7 run completes", op_n - base, 5 * DEPTH);

    repeat (20) @(negedge clk);
    check_eq("R8 status held", {fail, fail_addr, fail_act}, {1'b1, 3'd5, 4'hE});

    // disabled algorithm and out-of-range code
    start_run(3'd2, 7'h7B);
    repeat (40) @(negedge clk);
    check_eq("R9 disabled no ops", op_n - base, 0);
    check_eq("R9 disabled no done", done_n - dn0, 0);
    check_eq("R9 status unchanged", {fail, fail_addr, busy}, {1'b1, 3'd5, 1'b0});
    start_run(3'd7, 7'h7F);
    repeat (40) @(negedge clk);
    check_eq("R9 code 7 no ops", op_n - base, 0);
    check_eq("R9 code 7 no done", done_n - dn0, 0);

    start_run(3'd0, 7'h7F);
    wait_done();
    check_eq("R7 ascending first fail", {fail, fail_addr, fail_exp, fail_act},
             {1'b1, 3'd2, 4'hF, 4'hE});

    clear_faults();
    sa0[6] = 4'b0100;
    start_run(3'd5, 7'h7F);
    wait_done();
    check_eq("R7 stuck bit 2", {fail, fail_addr, fail_exp, fail_act},
             {1'b1, 3'd6, 4'hF, 4'hB});

    // start while running
    clear_faults();
    start_run(3'd0, 7'h7F);
    repeat (5) @(negedge clk);
    alg_sel = 3'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check_eq("R7 cleared by new start", fail, 1'b0);
    @(negedge clk);
    check_eq("R10 single done", done_n - dn0, 1);
    repeat (40) @(negedge clk);
    check_eq("R10 no extra ops", op_n - base, 4 * DEPTH);
    check_eq("R10 idle afterwards", {busy, done_n - dn0}, {1'b0, 32'd1});

    check_eq("R5 no op while read pending", viol, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule